// File: doc/BRIEF.md
# Prioritized Interrupt and Exception Control Unit

This block keeps the privileged control state that a simple RISC core needs to take interrupts and exceptions. It holds a status register with a three-level stack of mode and interrupt-enable pairs and a five-bit interrupt mask. It also holds a cause register that records the exception code and five pending-interrupt bits, the return address of the faulting instruction, and the offending virtual address. Five asynchronous hardware interrupt lines pass through a two-flop synchronizer. They are then latched as pending bits, which stay set until software clears them. The unit raises a registered interrupt request when the current level is enabled and at least one pending bit is unmasked. It also reports the most urgent such level.

The pipeline pulses `exc_take` when it enters a handler. That pulse pushes the mode stack and records the code, return address and, optionally, the bad address. It pulses `exc_ret` on return from a handler, which pops the stack. Software reaches the registers through a move-to/move-from port with a register number, a write strobe and a registered read result.

Top module: `excp_ctl_unit`

## Requirements
- R1: The status register is number 12. Its bits 5:0 hold three (mode, enable) pairs: current at 1:0, previous at 3:2 and oldest at 5:4. In each pair the enable is the low bit (1 = interrupts on) and the mode is the high bit (0 = kernel, 1 = user). Bits 14:10 hold the mask, one bit per level 0..4. A write stores exactly those bits, and every other bit reads as 0.
- R2: On `exc_take` the oldest pair takes the previous pair, the previous pair takes the current pair, and the current pair becomes 00 (kernel, disabled). `user_mode` always shows the current mode bit.
- R3: On `exc_ret` (without `exc_take`) the current pair takes the previous pair, the previous pair takes the oldest pair, and the oldest pair is unchanged. `exc_take` wins over `exc_ret`, and both win over a software write to the pair bits in the same cycle.
- R4: `irq_req` is 1 exactly when, one cycle earlier, the current enable was 1 and some pending bit had its mask bit set.
- R5: A synchronized line that is high sets its pending bit even while it is masked or disabled. The bit then stays set until software writes register 13 with a 0 in that bit position (bits 14:10). Writing a 1 does not set a bit, and a line that is still high sets it again.
- R6: `irq_lvl` is the index (0..4) of the highest-numbered pending bit whose mask bit is set, and 0 when there is none. Level 4 is the most urgent. The output is registered like `irq_req`.
- R7: The cause register is number 13. Its bits 6:2 hold the exception code, loaded from `exc_code` on `exc_take` and not writable by software. Bits 14:10 show the pending bits, and the other bits read 0.
- R8: Register 14 loads `exc_pc` on `exc_take`. Register 8 loads `exc_bad_addr` on `exc_take` only when `exc_bad_vld` is 1 and otherwise keeps its value. Software writes to both are ignored.
- R9: After reset all registers are 0, so `irq_req`, `irq_lvl`, `user_mode` and `reg_rdata` are 0.
- R10: A line that rises sets its pending bit on the third rising clock edge and `irq_req` on the fourth. `reg_rdata` gives, one edge after `reg_sel` is presented, the selected register's value from before that edge. Unlisted register numbers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 5 | Asynchronous hardware interrupt lines, level 4 most urgent |
| reg_sel | input | 5 | Register number for read and write |
| reg_wr | input | 1 | Write strobe (move-to) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data (move-from) |
| exc_take | input | 1 | Exception entry pulse |
| exc_code | input | 5 | Exception type code recorded on entry |
| exc_pc | input | 32 | Return address recorded on entry |
| exc_bad_vld | input | 1 | Bad virtual address is valid on this entry |
| exc_bad_addr | input | 32 | Bad virtual address |
| exc_ret | input | 1 | Return-from-exception pulse |
| irq_req | output | 1 | Interrupt request to the pipeline |
| irq_lvl | output | 3 | Most urgent enabled pending level |
| user_mode | output | 1 | Current mode bit (1 = user) |

## Verification
Directed sequences first pulse a line while it is masked and then unmask it. This separates a pending bit that is held from one that follows the line. A line is raised on an enabled level and the edges are counted, which exposes a missing or extra synchronizer stage. An entry followed by a return, with a user-mode current pair and with and without a valid bad address, tells the push from the pop and shows whether the oldest pair is kept. The random phase mixes sparse line changes with writes, entries and returns that often collide in one cycle. It compares every output on every cycle with a bench model, so errors in priority, masking and write precedence show up.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_BADVA  = 8;
  localparam int REG_STATUS = 12;
  localparam int REG_CAUSE  = 13;
  localparam int REG_EPC    = 14;
  localparam int PEND_LSB   = 10;
  localparam int CODE_LSB   = 2;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= 2'b00;
      else     sh <= {sh[0], din[g]};
    end
    assign dout[g] = sh[1];
  end
endmodule

// File: rtl/irqc_mode_stack.sv
module irqc_mode_stack #(
  parameter int DEPTH = 3,
  parameter int SW    = 2 * DEPTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_val,
  output logic [SW-1:0] stk
);
  always_ff @(posedge clk) begin
    if (rst)        stk <= '0;
    else if (push)  stk <= {stk[SW-3:0], 2'b00};
    else if (pop)   stk <= {stk[SW-1:SW-2], stk[SW-1:2]};
    else if (wr_en) stk <= wr_val;
  end

  // R2: entry shifts the pairs up and clears the current pair
  a_r2_push: assert property (@(posedge clk) disable iff (rst)
    push |=> (stk[1:0] == 2'b00) && (stk[SW-1:2] == $past(stk[SW-3:0])));

  // R3: return shifts down and keeps the oldest pair
  a_r3_pop: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (stk[SW-1:SW-2] == $past(stk[SW-1:SW-2])) &&
                       (stk[SW-3:0] == $past(stk[SW-1:2])));
endmodule

// File: rtl/irqc_pend_prio.sv
module irqc_pend_prio #(
  parameter int NLVL = 5,
  parameter int LVLW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] lvl_in,
  input  logic [NLVL-1:0] clr,
  input  logic [NLVL-1:0] mask,
  input  logic            ie,
  output logic [NLVL-1:0] pend,
  output logic            irq_req,
  output logic [LVLW-1:0] irq_lvl
);
  logic [NLVL-1:0] act;
  logic [LVLW-1:0] lvl_n;

  assign act = pend & mask;

  always_comb begin
    lvl_n = '0;
    for (int i = 0; i < NLVL; i++)
      if (act[i]) lvl_n = LVLW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      irq_req <= 1'b0;
      irq_lvl <= '0;
    end else begin
      pend    <= (pend & ~clr) | lvl_in;
      irq_req <= ie && (|act);
      irq_lvl <= lvl_n;
    end
  end

  // R4: no request follows a cycle with interrupts disabled
  a_r4_gate: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq_req);

  // R5: without a clear, no pending bit is dropped
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (clr == '0) |=> (($past(pend) & ~pend) == '0));
endmodule

// File: rtl/excp_ctl_unit.sv
module excp_ctl_unit
  import irqc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NLVL  = 5,
  parameter int CODEW = 5,
  parameter int SELW  = 5,
  parameter int DEPTH = 3,
  parameter int LVLW  = $clog2(NLVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLVL-1:0]  irq_in,
  input  logic [SELW-1:0]  reg_sel,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             exc_take,
  input  logic [CODEW-1:0] exc_code,
  input  logic [DW-1:0]    exc_pc,
  input  logic             exc_bad_vld,
  input  logic [DW-1:0]    exc_bad_addr,
  input  logic             exc_ret,
  output logic             irq_req,
  output logic [LVLW-1:0]  irq_lvl,
  output logic             user_mode
);
  localparam int SW = 2 * DEPTH;

  logic [NLVL-1:0]  lvl_sync, pend, clr, mask_q;
  logic [SW-1:0]    stk;
  logic [CODEW-1:0] code_q;
  logic [DW-1:0]    epc_q, bad_q, status_v, cause_v;
  logic             wr_status, wr_cause;
  logic             unused_wdata;

  assign wr_status = reg_wr && (reg_sel == SELW'(REG_STATUS));
  assign wr_cause  = reg_wr && (reg_sel == SELW'(REG_CAUSE));
  assign clr       = wr_cause ? ~reg_wdata[PEND_LSB +: NLVL] : '0;
  assign unused_wdata = ^reg_wdata;

  irqc_sync #(.W(NLVL)) u_sync (
    .clk(clk), .rst(rst), .din(irq_in), .dout(lvl_sync)
  );

  irqc_mode_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(exc_take), .pop(exc_ret),
    .wr_en(wr_status), .wr_val(reg_wdata[SW-1:0]), .stk(stk)
  );

  irqc_pend_prio #(.NLVL(NLVL), .LVLW(LVLW)) u_pend (
    .clk(clk), .rst(rst), .lvl_in(lvl_sync), .clr(clr), .mask(mask_q),
    .ie(stk[0]), .pend(pend), .irq_req(irq_req), .irq_lvl(irq_lvl)
  );

  assign user_mode = stk[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      code_q <= '0;
      epc_q  <= '0;
      bad_q  <= '0;
    end else begin
      if (wr_status) mask_q <= reg_wdata[PEND_LSB +: NLVL];
      if (exc_take) begin
        code_q <= exc_code;
        epc_q  <= exc_pc;
        if (exc_bad_vld) bad_q <= exc_bad_addr;
      end
    end
  end

  always_comb begin
    status_v = '0;
    status_v[SW-1:0] = stk;
    status_v[PEND_LSB +: NLVL] = mask_q;
    cause_v = '0;
    cause_v[CODE_LSB +: CODEW] = code_q;
    cause_v[PEND_LSB +: NLVL] = pend;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_sel)
        SELW'(REG_STATUS): reg_rdata <= status_v;
        SELW'(REG_CAUSE):  reg_rdata <= cause_v;
        SELW'(REG_EPC):    reg_rdata <= epc_q;
        SELW'(REG_BADVA):  reg_rdata <= bad_q;
        default:           reg_rdata <= '0;
      endcase
    end
  end

  // R8: the bad address only moves on an entry that flags it valid
  a_r8_bad_hold: assert property (@(posedge clk) disable iff (rst)
    !(exc_take && exc_bad_vld) |=> $stable(bad_q));

  // R7: the code field only moves on an entry
  a_r7_code_hold: assert property (@(posedge clk) disable iff (rst)
    !exc_take |=> $stable(code_q));
endmodule

// File: tb/excp_ctl_unit_test.sv
`timescale 1ns/1ps
module excp_ctl_unit_test;
  localparam time TCLK = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  irq_in = '0;
  logic [4:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        exc_take = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic        exc_bad_vld = 1'b0;
  logic [31:0] exc_bad_addr = '0;
  logic        exc_ret = 1'b0;
  logic        irq_req;
  logic [2:0]  irq_lvl;
  logic        user_mode;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  excp_ctl_unit uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc_take(exc_take),
    .exc_code(exc_code), .exc_pc(exc_pc), .exc_bad_vld(exc_bad_vld),
    .exc_bad_addr(exc_bad_addr), .exc_ret(exc_ret), .irq_req(irq_req),
    .irq_lvl(irq_lvl), .user_mode(user_mode)
  );

  // bench model built from the requirements
  logic [4:0]  m_s1, m_s2, m_pend, m_mask, m_code;
  logic [5:0]  m_stk;
  logic [31:0] m_epc, m_bad, m_rd;
  logic        m_req;
  logic [2:0]  m_lvl;

  function automatic logic [2:0] top_lvl(input logic [4:0] v);
    top_lvl = 3'd0;
    for (int i = 0; i < 5; i++) if (v[i]) top_lvl = 3'(i);
  endfunction

  function automatic logic [31:0] model_read(input logic [4:0] s);
    case (s)
      5'd12:   model_read = {17'd0, m_mask, 4'd0, m_stk};
      5'd13:   model_read = {17'd0, m_pend, 3'd0, m_code, 2'd0};
      5'd14:   model_read = m_epc;
      5'd8:    model_read = m_bad;
      default: model_read = 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_pend <= '0; m_mask <= '0; m_code <= '0;
      m_stk <= '0; m_epc <= '0; m_bad <= '0; m_rd <= '0; m_req <= 1'b0; m_lvl <= '0;
    end else begin
      m_s1 <= irq_in;
      m_s2 <= m_s1;
      m_pend <= (m_pend & ~((reg_wr && reg_sel == 5'd13) ? ~reg_wdata[14:10] : 5'd0)) | m_s2;
      if (exc_take)     m_stk <= {m_stk[3:0], 2'b00};
      else if (exc_ret) m_stk <= {m_stk[5:4], m_stk[5:2]};
      else if (reg_wr && reg_sel == 5'd12) m_stk <= reg_wdata[5:0];
      if (reg_wr && reg_sel == 5'd12) m_mask <= reg_wdata[14:10];
      if (exc_take) begin
        m_code <= exc_code;
        m_epc  <= exc_pc;
        if (exc_bad_vld) m_bad <= exc_bad_addr;
      end
      m_req <= m_stk[0] && |(m_pend & m_mask);
      m_lvl <= top_lvl(m_pend & m_mask);
      m_rd  <= model_read(reg_sel);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  logic [4:0] sel_d;
  always @(posedge clk) sel_d <= reg_sel;
  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 irq_req", {31'd0, irq_req}, {31'd0, m_req});
      chk("R6 irq_lvl", {29'd0, irq_lvl}, {29'd0, m_lvl});
      chk("R2 user_mode", {31'd0, user_mode}, {31'd0, m_stk[1]});
      case (sel_d)
        5'd12:   chk("R1 status read", reg_rdata, m_rd);
        5'd13:   chk("R7 cause read", reg_rdata, m_rd);
        5'd14:   chk("R8 epc read", reg_rdata, m_rd);
        5'd8:    chk("R8 badva read", reg_rdata, m_rd);
        default: chk("R10 unlisted read", reg_rdata, m_rd);
      endcase
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [4:0] s, input logic [31:0] d);
    reg_sel = s; reg_wr = 1'b1; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(TCLK * 200000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R9 reset state
    chk("R9 irq_req after reset", {31'd0, irq_req}, 32'd0);
    chk("R9 irq_lvl after reset", {29'd0, irq_lvl}, 32'd0);
    chk("R9 user_mode after reset", {31'd0, user_mode}, 32'd0);
    chk("R9 rdata after reset", reg_rdata, 32'd0);

    // R5: a pulse while masked is held
    wr_reg(5'd12, 32'h0000_0001);
    irq_in = 5'b00100;
    cyc();
    irq_in = 5'b00000;
    repeat (5) cyc();
    chk("R5 masked pulse gives no request", {31'd0, irq_req}, 32'd0);
    reg_sel = 5'd13;
    cyc();
    chk("R5 masked pulse stays pending", reg_rdata, 32'h0000_1000);
    wr_reg(5'd12, 32'h0000_7C01);
    cyc();
    chk("R4 request after unmask", {31'd0, irq_req}, 32'd1);
    chk("R6 level of held pulse", {29'd0, irq_lvl}, 32'd2);
    wr_reg(5'd13, 32'h0000_1000);
    cyc();
    chk("R5 writing one keeps bit", {31'd0, irq_req}, 32'd1);
    wr_reg(5'd13, 32'h0000_0000);
    cyc();
    chk("R5 cleared by writing zero", {31'd0, irq_req}, 32'd0);

    // R10: synchronizer latency
    irq_in = 5'b10000;
    repeat (3) cyc();
    chk("R10 no request at third edge", {31'd0, irq_req}, 32'd0);
    cyc();
    chk("R10 request at fourth edge", {31'd0, irq_req}, 32'd1);
    chk("R6 level four", {29'd0, irq_lvl}, 32'd4);
    irq_in = 5'b00000;
    repeat (3) cyc();
    wr_reg(5'd13, 32'h0000_0000);
    cyc();

    // R2/R3/R7/R8 entry and return
    wr_reg(5'd12, 32'h0000_7C03);
    exc_take = 1'b1; exc_code = 5'd9; exc_pc = 32'h1000_0040;
    exc_bad_vld = 1'b1; exc_bad_addr = 32'hDEAD_0000;
    cyc();
    exc_take = 1'b0; exc_bad_vld = 1'b0;
    chk("R2 kernel after entry", {31'd0, user_mode}, 32'd0);
    reg_sel = 5'd12; cyc();
    chk("R2 stack pushed", reg_rdata, 32'h0000_7C0C);
    reg_sel = 5'd13; cyc();
    chk("R7 code recorded", reg_rdata, 32'h0000_0024);
    reg_sel = 5'd14; cyc();
    chk("R8 epc recorded", reg_rdata, 32'h1000_0040);
    reg_sel = 5'd8; cyc();
    chk("R8 badva recorded", reg_rdata, 32'hDEAD_0000);
    exc_ret = 1'b1; cyc(); exc_ret = 1'b0;
    chk("R3 user after return", {31'd0, user_mode}, 32'd1);
    reg_sel = 5'd12; cyc();
    chk("R3 stack popped", reg_rdata, 32'h0000_7C03);
    exc_take = 1'b1; exc_bad_vld = 1'b0; exc_bad_addr = 32'h1234_5678;
    exc_ret = 1'b1;
    cyc();
    exc_take = 1'b0; exc_ret = 1'b0;
    reg_sel = 5'd8; cyc();
    chk("R8 badva kept when not valid", reg_rdata, 32'hDEAD_0000);
    reg_sel = 5'd12; cyc();
    chk("R3 entry wins over return", reg_rdata, 32'h0000_7C0C);
    wr_reg(5'd8, 32'hFFFF_FFFF);
    reg_sel = 5'd8; cyc();
    chk("R8 software write ignored", reg_rdata, 32'hDEAD_0000);

    // random phase, checked by the model every cycle
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 6 == 0) irq_in = 5'($urandom);
      case ($urandom % 5)
        0: reg_sel = 5'd8;
        1: reg_sel = 5'd12;
        2: reg_sel = 5'd13;
        3: reg_sel = 5'd14;
        default: reg_sel = 5'($urandom);
      endcase
      reg_wr       = ($urandom % 5 == 0);
      reg_wdata    = $urandom;
      exc_take     = ($urandom % 12 == 0);
      exc_code     = 5'($urandom);
      exc_pc       = $urandom;
      exc_bad_vld  = ($urandom % 2 == 0);
      exc_bad_addr = $urandom;
      exc_ret      = ($urandom % 9 == 0);
      cyc();
    end
    reg_wr = 1'b0; exc_take = 1'b0; exc_ret = 1'b0;
    cyc();
    finish_run();
  end
endmodule